// File: doc/BRIEF.md
# Shared Prescaler Tick Divider

This block turns one peripheral clock into five count-enable strobes for a five-channel timer. Two 8-bit prescalers run from the clock. Channels 0 and 1 use the first one, and channels 2, 3 and 4 use the second. Behind its prescaler, each channel has a power-of-two divider. A 4-bit select code per channel picks the divider.

The select code is offset by a build-time base. With base 0, code 0 means divide-by-1. With base 1, code 0 means divide-by-2. Codes that would exceed the largest supported divisor are held at that divisor. A new prescaler value waits until the running prescale period completes, so the timer never sees a shortened interval. The counters that consume the strobes sit outside this block.

Top module: `tick_divider`

## Requirements
- R1: `prescale_cfg[7:0]` drives the prescaler of channels 0 and 1, and `prescale_cfg[15:8]` drives the prescaler of channels 2, 3 and 4.
- R2: A prescaler value N produces one prescaler pulse every N+1 clock cycles.
- R3: Channel c reads its select code from `divsel_cfg[4c+3:4c]`. Its divisor is 2 to the power (code + DIV_BASE).
- R4: With DIV_BASE=0, select code 0 gives divide-by-1. With DIV_BASE=1, select code 0 gives divide-by-2.
- R5: Each tick output is high for one clock cycle in every (N+1)*2^k cycles, where k is the effective shift. If the total ratio is 1, the tick is high on every cycle.
- R6: A new prescaler value is taken only when that prescaler completes its current period. The interval in progress when the value changes keeps the old length.
- R7: If code + DIV_BASE is greater than MAX_SHIFT (default 4), the divider uses 2^MAX_SHIFT.
- R8: The active-low reset is synchronous. It clears every prescaler counter, every held prescaler limit and every divider counter to zero. As a result, each prescaler pulses in the first cycle after reset is released, and the programmed value applies from that pulse on.
- R9: A tick occurs only in a cycle in which its group's prescaler pulses. Two channels of the same group with equal select codes tick in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prescale_cfg | input | 16 | Two prescaler values: low byte for group 0, high byte for group 1 |
| divsel_cfg | input | 20 | Five 4-bit divider select codes, channel c at bits 4c+3:4c |
| tick | output | 5 | Single-cycle count enables, one per channel |

## Verification
The assertions check several properties on every cycle. A prescaler count never exceeds its held limit. A pulse returns the count to zero. The held limit changes only on a pulse, and divider counters move only on a pulse. Each tick coincides with its group's pulse, and same-group channels with equal codes tick together. The exact tick period, the field positions, the base offset between the two variants, the clamping of large codes and the deferred prescaler update can only be seen in the bench. There, a behavioural model is compared against the outputs on every cycle, and measured tick intervals are checked against the ratios expected from the requirements.

// File: rtl/tick_div_pkg.sv
// Shared definitions for the tick divider.
// Assumes: exactly two prescaler groups; channels below the split index use group 0.
package tick_div_pkg;

    localparam int NUM_GROUPS = 2;

    // Returns the prescaler group that serves a channel.
    function automatic int group_of(input int ch, input int split);
        return (ch < split) ? 0 : 1;
    endfunction

endpackage

// File: rtl/tdiv_prescaler.sv
// Prescaler: pulses once every (limit+1) cycles.
// The limit in force is held internally and is reloaded from limit_in only
// when the count wraps, so a changed value never shortens a running period.
// Assumes: limit_in may change on any cycle.
module tdiv_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] limit_in,
    output logic         pulse
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] lim_q;

    // Pulse when the count reaches the held limit.
    assign pulse = (cnt_q == lim_q);

    // Count up, wrap on pulse and pick up the new limit only then.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (pulse) begin
            cnt_q <= '0;
            lim_q <= limit_in;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_q); // R2
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> (cnt_q == '0)); // R2
    AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse |=> $stable(lim_q)); // R6

endmodule

// File: rtl/tdiv_pow2.sv
// Power-of-two divider for one channel.
// A free-running counter advances on each prescaler pulse. The tick fires on
// a pulse when the low k bits of the counter are all ones, with
// k = min(sel + DIV_BASE, MAX_SHIFT).
// Assumes: MAX_SHIFT >= 1.
module tdiv_pow2 #(
    parameter int SEL_W     = 4,
    parameter int MAX_SHIFT = 4,
    parameter int DIV_BASE  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_pulse,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int CW  = MAX_SHIFT;
    localparam int SHW = $clog2(MAX_SHIFT + 1);

    logic [CW-1:0]  dcnt_q;
    logic [SHW-1:0] shift;
    logic [CW:0]    full_mask;
    logic [CW-1:0]  mask;
    int unsigned    sum_v;

    // Effective shift: offset the code by the base and clamp to the maximum.
    always_comb begin
        sum_v = int'(sel) + DIV_BASE;
        if (sum_v > MAX_SHIFT) shift = SHW'(MAX_SHIFT);
        else                   shift = SHW'(sum_v);
    end

    // Mask covering the low k counter bits.
    assign full_mask = ((CW+1)'(1) << shift) - (CW+1)'(1);
    assign mask      = full_mask[CW-1:0];
    assign tick      = pre_pulse && ((dcnt_q & mask) == mask);

    // Advance the divider counter on each prescaler pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)         dcnt_q <= '0;
        else if (pre_pulse) dcnt_q <= dcnt_q + 1'b1;
    end

    AST_TICK_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> pre_pulse); // R9
    AST_DCNT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_pulse |=> $stable(dcnt_q)); // R5

endmodule

// File: rtl/tick_divider.sv
// Top: two shared prescalers feeding one power-of-two divider per channel.
// Channels below SPLIT_CH use prescaler 0 (prescale_cfg low byte); the
// rest use prescaler 1 (high byte).
// Assumes: NUM_CH > SPLIT_CH >= 1.
module tick_divider #(
    parameter int NUM_CH    = 5,
    parameter int SPLIT_CH  = 2,
    parameter int PRE_W     = 8,
    parameter int SEL_W     = 4,
    parameter int MAX_SHIFT = 4,
    parameter int DIV_BASE  = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2*PRE_W-1:0]      prescale_cfg,
    input  logic [NUM_CH*SEL_W-1:0] divsel_cfg,
    output logic [NUM_CH-1:0]       tick
);
    import tick_div_pkg::*;

    logic [NUM_GROUPS-1:0] pre_pulse;

    // One prescaler per channel group.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_pre
        tdiv_prescaler #(.W(PRE_W)) u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .limit_in (prescale_cfg[g*PRE_W +: PRE_W]),
            .pulse    (pre_pulse[g])
        );
    end

    // One divider per channel, fed by its group's prescaler.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int GRP = group_of(c, SPLIT_CH);
        tdiv_pow2 #(.SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT), .DIV_BASE(DIV_BASE)) u_div (
            .clk       (clk),
            .rst_n     (rst_n),
            .pre_pulse (pre_pulse[GRP]),
            .sel       (divsel_cfg[c*SEL_W +: SEL_W]),
            .tick      (tick[c])
        );
    end

    AST_GROUP0_SAME_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (divsel_cfg[0 +: SEL_W] == divsel_cfg[SEL_W +: SEL_W]) |-> (tick[0] == tick[1])); // R9
    AST_GROUP1_SAME_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (divsel_cfg[SPLIT_CH*SEL_W +: SEL_W] == divsel_cfg[(NUM_CH-1)*SEL_W +: SEL_W])
        |-> (tick[SPLIT_CH] == tick[NUM_CH-1])); // R9

endmodule

// File: tb/tick_divider_tb.sv
`timescale 1ns/1ps
module tick_divider_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pcfg = 16'h0302;
    logic [19:0] dcfg = 20'h11110;
    logic [4:0]  tick_a;
    logic [4:0]  tick_b;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R8";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    tick_divider u_dut (
        .clk(clk), .rst_n(rst_n), .prescale_cfg(pcfg), .divsel_cfg(dcfg), .tick(tick_a));

    tick_divider #(.DIV_BASE(1)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .prescale_cfg(pcfg), .divsel_cfg(dcfg), .tick(tick_b));

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference for u_dut (base 0, max shift 4).
    int m_pc[2];
    int m_pl[2];
    int m_dc[5];

    function automatic int grp(input int c);
        return (c < 2) ? 0 : 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < 2; g++) begin m_pc[g] = 0; m_pl[g] = 0; end
            for (int c = 0; c < 5; c++) m_dc[c] = 0;
        end else begin
            bit mp[2];
            for (int g = 0; g < 2; g++) mp[g] = (m_pc[g] == m_pl[g]);
            for (int c = 0; c < 5; c++) if (mp[grp(c)]) m_dc[c] = (m_dc[c] + 1) % 16;
            for (int g = 0; g < 2; g++) begin
                if (mp[g]) begin
                    m_pc[g] = 0;
                    m_pl[g] = (g == 0) ? int'(pcfg[7:0]) : int'(pcfg[15:8]);
                end else begin
                    m_pc[g] = m_pc[g] + 1;
                end
            end
        end
    end

    function automatic bit exp_tick(input int c);
        int k;
        int p;
        k = int'((dcfg >> (4*c)) & 20'hF);
        if (k > 4) k = 4;
        p = 1 << k;
        return (m_pc[grp(c)] == m_pl[grp(c)]) && ((m_dc[c] % p) == p - 1);
    endfunction

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < 5; c++)
                chk(tick_a[c] == exp_tick(c), cur_req, $sformatf("model tick ch%0d", c),
                    int'(tick_a[c]), int'(exp_tick(c)));
        end
    end

    function automatic bit tk(input int inst, input int ch);
        return (inst == 0) ? tick_a[ch] : tick_b[ch];
    endfunction

    task automatic wait_tick(input int inst, input int ch);
        int guard = 0;
        do begin @(negedge clk); guard++; end while (!tk(inst, ch) && guard < 5000);
    endtask

    task automatic count_to_tick(input int inst, input int ch, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!tk(inst, ch) && n < 5000);
    endtask

    task automatic measure(input int inst, input int ch, input int exp, input string req);
        int n;
        wait_tick(inst, ch);
        count_to_tick(inst, ch, n);
        chk(n == exp, req, $sformatf("period inst%0d ch%0d", inst, ch), n, exp);
    endtask

    task automatic set_cfg(input logic [15:0] p, input logic [19:0] d);
        @(posedge clk); #1;
        pcfg = p;
        dcfg = d;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        summary();
    end

    initial begin
        int n;
        int same;
        // R8: reset state and first pulse right after release.
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(tick_a == 5'b00001, "R8", "ticks after reset", int'(tick_a), 1);
        chk(tick_b == 5'b00000, "R8", "ticks after reset base1", int'(tick_b), 0);

        // R1, R5: p0=2 (ratio 3), p1=3 (ratio 4).
        cur_req = "R5";
        measure(0, 0, 3, "R5");
        measure(0, 2, 8, "R1");
        measure(0, 1, 6, "R1");

        // R3: distinct codes per field.
        cur_req = "R3";
        set_cfg(16'h0302, 20'h42031);
        repeat (70) @(negedge clk);
        measure(0, 0, 6, "R3");
        measure(0, 1, 24, "R3");
        measure(0, 2, 4, "R3");
        measure(0, 3, 16, "R3");
        measure(0, 4, 64, "R3");

        // R7: clamping of large codes.
        cur_req = "R7";
        set_cfg(16'h0302, 20'hF5004);
        repeat (70) @(negedge clk);
        measure(0, 4, 64, "R7");
        measure(0, 3, 64, "R7");
        measure(1, 0, 48, "R7");
        measure(0, 0, 48, "R7");

        // R4: base offset between variants.
        cur_req = "R4";
        set_cfg(16'h0302, 20'h00000);
        repeat (70) @(negedge clk);
        measure(0, 2, 4, "R4");
        measure(1, 2, 8, "R4");
        measure(0, 0, 3, "R4");
        measure(1, 0, 6, "R4");

        // R2: a larger prescaler value.
        cur_req = "R2";
        set_cfg(16'h1307, 20'h00000);
        repeat (40) @(negedge clk);
        measure(0, 0, 8, "R2");
        measure(0, 3, 20, "R2");

        // R6: change taken only at the next wrap.
        cur_req = "R6";
        set_cfg(16'h1302, 20'h00000);
        repeat (40) @(negedge clk);
        wait_tick(0, 0);
        @(posedge clk); #1 pcfg[7:0] = 8'd9;
        count_to_tick(0, 0, n);
        chk(n == 3, "R6", "interval spanning change", n, 3);
        count_to_tick(0, 0, n);
        chk(n == 10, "R6", "interval after change", n, 10);

        // R9: same-group equal codes tick together, only on pulses.
        cur_req = "R9";
        set_cfg(16'h0401, 20'h33211);
        same = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (tick_a[0] == tick_a[1] && tick_a[3] == tick_a[4]) same++;
        end
        chk(same == 200, "R9", "aligned cycles", same, 200);

        // R8: reset in mid-run returns to the initial state.
        cur_req = "R8";
        @(posedge clk); #1 rst_n = 1'b0; dcfg = 20'h11110;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(tick_a == 5'b00001, "R8", "ticks after second reset", int'(tick_a), 1);
        repeat (20) @(negedge clk);

        done = 1'b1;
        summary();
    end

endmodule